// File: doc/BRIEF.md
# Ordered Power-of-Two Clock Prescaler Bank

This block takes one main clock and produces three slower clock domains. Each domain runs at the main rate divided by a power of two, from 1 up to 128. All three domains are timed from one shared free-running counter. Each domain drives a one-cycle enable pulse, `dom_tick[n]`. The pulse marks the cycle in which that domain's divided clock has its falling edge. Downstream logic uses the pulse as a clock enable.

Software sets each domain's ratio through a small register interface, one 8-bit ratio register per domain. A new ratio is held pending and does not take effect at once. The domain changes only in a cycle where the falling edges of the old and new divided clocks line up, so the output never produces a runt period. A ready flag goes high once every pending change has been applied. Writes are rejected if the value is not a legal ratio or if it would make a lower-numbered domain slower than a higher-numbered one.

Top module: `domain_prescaler`

## Requirements
- R1: After reset every ratio register reads 1, every `dom_tick` bit is high in every cycle (divide by 1), the internal counter starts at 0, and `clk_ready` is 0.
- R2: With domain n committed to ratio 2^k, `dom_tick[n]` is high exactly in the cycles where the low k bits of the shared counter are zero. The counter starts at 0 and advances by one on each main clock edge after reset is released, wrapping modulo 128.
- R3: A write to a ratio register whose bits 7:0 are not one of 1, 2, 4, 8, 16, 32, 64 or 128 is ignored. Bits 31:8 of the write data are don't-care. The register, the ticks and `clk_ready` are unchanged.
- R4: A legal write to domain n is ignored if its exponent is below the pending exponent of domain n-1, or above the pending exponent of domain n+1.
- R5: An accepted write leaves the domain on its old ratio until the first cycle in which the counter's low max(k_old, k_new) bits are all zero. The new ratio applies from the following cycle, and the pulse in the switch cycle is common to both ratios.
- R6: `clk_ready` clears on the edge that accepts a ratio write. It also clears on a write to byte offset 0x04 with data bit 0 set. It sets on the edge where the last pending switch is applied.
- R7: Reads are combinational. Offset 0x0C+4n returns domain n's committed ratio (2^k) in bits 7:0, not the pending one. Offset 0x04 returns `clk_ready` in bit 0. All other bits and all other offsets read as 0.
- R8: A write to offset 0x04 with data bit 0 clear has no effect on `clk_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| dom_tick | output | 3 | Per-domain falling-edge enable pulse |
| clk_ready | output | 1 | All pending ratio switches applied |

## Verification
The hardest case to reach is a switch still waiting when another write lands. That includes a second write to the same domain in the cycle its first switch commits, and writes whose legality depends on a neighbour's still-pending ratio. The bench raises and lowers all three domains through every ratio in the only order the rule allows. It then sweeps all 256 byte values into the middle domain while its neighbours sit at the extremes, and issues back-to-back writes to a domain while a slow switch is still waiting. A cycle-accurate model written from the requirements predicts every pulse and the ready flag in every cycle.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int FIELD_W = 8;
  localparam int BUS_W   = 32;
  localparam logic [7:0] STAT_OFS   = 8'h04;
  localparam logic [7:0] RATIO_BASE = 8'h0C;
  localparam int RATIO_STEP = 4;
endpackage

// File: rtl/dp_counter.sv
module dp_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_nxt;

  always_comb cnt_nxt = cnt + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/dp_regs.sv
module dp_regs
  import dp_pkg::*;
#(
  parameter int NDOM = 3,
  parameter int KMAX = 7,
  parameter int KW   = 3,
  parameter int AW   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [AW-1:0]              bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  input  logic [NDOM-1:0]            commit,
  output logic [NDOM-1:0][KW-1:0]    tgt_k,
  output logic [NDOM-1:0]            pend,
  output logic                       acc_any
);
  logic [KW-1:0]           w_exp;
  logic                    w_legal;
  logic [NDOM-1:0]         hit, lo_ok, hi_ok, acc;
  logic [NDOM-1:0][KW-1:0] tgt_nxt;
  logic [NDOM-1:0]         pend_nxt;

  always_comb begin
    w_exp   = '0;
    w_legal = $onehot(bus_wdata[FIELD_W-1:0]);
    for (int i = 0; i < FIELD_W; i++) begin
      if (bus_wdata[i]) begin
        if (i > KMAX) w_legal = 1'b0;
        else          w_exp   = i[KW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NDOM; g++) begin : g_dec
    assign hit[g] = bus_wr && (bus_addr == AW'(int'(RATIO_BASE) + RATIO_STEP * g));
    if (g == 0) begin : g_lo0
      assign lo_ok[g] = 1'b1;
    end else begin : g_lo
      assign lo_ok[g] = (w_exp >= tgt_k[g-1]);
    end
    if (g == NDOM - 1) begin : g_hiN
      assign hi_ok[g] = 1'b1;
    end else begin : g_hi
      assign hi_ok[g] = (w_exp <= tgt_k[g+1]);
    end
    assign acc[g] = hit[g] && w_legal && lo_ok[g] && hi_ok[g];
  end

  assign acc_any = |acc;

  always_comb begin
    for (int n = 0; n < NDOM; n++) begin
      tgt_nxt[n] = acc[n] ? w_exp : tgt_k[n];
    end
    pend_nxt = (pend & ~commit) | acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_k <= '0;
      pend  <= '0;
    end else begin
      tgt_k <= tgt_nxt;
      pend  <= pend_nxt;
    end
  end

  p_bad_value_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !$onehot(bus_wdata[FIELD_W-1:0])) |=> tgt_k == $past(tgt_k));

  for (genvar g = 1; g < NDOM; g++) begin : g_ord
    p_order_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_k[g] >= tgt_k[g-1]);
  end
endmodule

// File: rtl/dp_domain.sv
module dp_domain #(
  parameter int KMAX = 7,
  parameter int KW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KMAX-1:0] cnt,
  input  logic [KW-1:0]   tgt_k,
  input  logic            pend,
  output logic [KW-1:0]   cur_k,
  output logic            tick,
  output logic            commit
);
  function automatic logic [KMAX-1:0] low_mask(input logic [KW-1:0] k);
    logic [KMAX-1:0] m;
    for (int i = 0; i < KMAX; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  logic [KW-1:0] k_wide;
  logic          coincide;
  logic [KW-1:0] cur_nxt;

  always_comb begin
    k_wide   = (cur_k > tgt_k) ? cur_k : tgt_k;
    coincide = ((cnt & low_mask(k_wide)) == '0);
    tick     = ((cnt & low_mask(cur_k)) == '0);
    commit   = pend && coincide;
    cur_nxt  = commit ? tgt_k : cur_k;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_k <= '0;
    else        cur_k <= cur_nxt;
  end

  p_hold_until_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> cur_k == $past(cur_k));
  p_switch_on_shared_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (tick && ((cnt & low_mask(tgt_k)) == '0)));
endmodule

// File: rtl/domain_prescaler.sv
module domain_prescaler
  import dp_pkg::*;
#(
  parameter int NDOM = 3,
  parameter int KMAX = 7,
  parameter int AW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [NDOM-1:0]  dom_tick,
  output logic             clk_ready
);
  localparam int KW = $clog2(KMAX + 1);

  logic [KMAX-1:0]         cnt;
  logic [NDOM-1:0][KW-1:0] tgt_k, cur_k;
  logic [NDOM-1:0]         pend, commit;
  logic                    acc_any, w1c, done_evt, ready_nxt;

  dp_counter #(.W(KMAX)) u_cnt (.clk(clk), .rst_n(rst_n), .cnt(cnt));

  dp_regs #(.NDOM(NDOM), .KMAX(KMAX), .KW(KW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .commit(commit), .tgt_k(tgt_k), .pend(pend),
    .acc_any(acc_any));

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    dp_domain #(.KMAX(KMAX), .KW(KW)) u_dom (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .tgt_k(tgt_k[g]), .pend(pend[g]),
      .cur_k(cur_k[g]), .tick(dom_tick[g]), .commit(commit[g]));
  end

  always_comb begin
    w1c      = bus_wr && (bus_addr == AW'(STAT_OFS)) && bus_wdata[0];
    done_evt = (|commit) && ((pend & ~commit) == '0);
    if (acc_any || w1c) ready_nxt = 1'b0;
    else if (done_evt)  ready_nxt = 1'b1;
    else                ready_nxt = clk_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_ready <= 1'b0;
    else        clk_ready <= ready_nxt;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(STAT_OFS)) bus_rdata[0] = clk_ready;
    for (int n = 0; n < NDOM; n++) begin
      if (bus_addr == AW'(int'(RATIO_BASE) + RATIO_STEP * n))
        bus_rdata[FIELD_W-1:0] = FIELD_W'(1) << cur_k[n];
    end
  end

  p_ready_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any |=> !clk_ready);
  p_ready_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ready) |-> $past(|commit));
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:FIELD_W] == '0);
endmodule

// File: tb/sim_domain_prescaler.sv
`timescale 1ns/1ps
module sim_domain_prescaler;
  localparam int NDOM = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [2:0]  dom_tick;
  logic        clk_ready;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  domain_prescaler u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dom_tick(dom_tick), .clk_ready(clk_ready));

  // reference model from the requirements
  logic [6:0] mcnt;
  logic [2:0] mcur [NDOM];
  logic [2:0] mtgt [NDOM];
  logic [NDOM-1:0] mpend;
  logic mready;

  function automatic logic [6:0] msk(input logic [2:0] k);
    return 7'((8'd1 << k) - 8'd1);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [NDOM-1:0] cm, hv;
    logic [2:0] e, kk;
    logic lg;
    if (!rst_n) begin
      mcnt <= '0; mpend <= '0; mready <= 1'b0;
      for (int n = 0; n < NDOM; n++) begin mcur[n] <= '0; mtgt[n] <= '0; end
    end else begin
      mcnt <= mcnt + 7'd1;
      cm = '0; hv = '0;
      for (int n = 0; n < NDOM; n++) begin
        kk = (mcur[n] > mtgt[n]) ? mcur[n] : mtgt[n];
        if (mpend[n] && ((mcnt & msk(kk)) == 7'd0)) begin cm[n] = 1'b1; mcur[n] <= mtgt[n]; end
      end
      lg = $onehot(bus_wdata[7:0]);
      e = '0;
      for (int i = 0; i < 8; i++) if (bus_wdata[i]) e = 3'(i);
      if (bus_wr && lg)
        for (int n = 0; n < NDOM; n++)
          if (bus_addr == 8'(12 + 4*n) && (n == 0 || e >= mtgt[n-1]) &&
              (n == NDOM-1 || e <= mtgt[n+1])) begin
            hv[n] = 1'b1; mtgt[n] <= e;
          end
      mpend <= (mpend & ~cm) | hv;
      if (hv != 0 || (bus_wr && bus_addr == 8'h04 && bus_wdata[0])) mready <= 1'b0;
      else if (cm != 0 && (mpend & ~cm) == 0) mready <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison of pulses and ready flag (R2, R5, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      for (int n = 0; n < NDOM; n++)
        chk(dom_tick[n] == ((mcnt & msk(mcur[n])) == 7'd0), "R2/R5 tick",
            dom_tick[n], (mcnt & msk(mcur[n])) == 7'd0);
      chk(clk_ready == mready, "R6 ready", clk_ready, mready);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    logic [31:0] ex;
    @(negedge clk); bus_addr = a; #1;
    ex = 32'h0;
    if (a == 8'h04) ex[0] = mready;
    for (int n = 0; n < NDOM; n++) if (a == 8'(12 + 4*n)) ex = 32'(8'd1 << mcur[n]);
    chk(bus_rdata == ex, req, bus_rdata, ex);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 300 && !clk_ready; i++) @(negedge clk);
    chk(clk_ready == 1'b1, "R6 ready after switch", clk_ready, 1);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] old;
    repeat (3) @(negedge clk);
    // R1: reset state, reset still asserted
    for (int n = 0; n < NDOM; n++) begin
      bus_addr = 8'(12 + 4*n); #1;
      chk(bus_rdata == 32'd1, "R1 reset ratio", bus_rdata, 1);
    end
    chk(dom_tick == 3'b111, "R1 reset ticks", dom_tick, 7);
    chk(clk_ready == 1'b0, "R1 reset ready", clk_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_n(4);
    // R2: raise all domains through every ratio, top domain first
    for (int k = 1; k < 8; k++) begin
      for (int n = NDOM-1; n >= 0; n--) wr(8'(12 + 4*n), 32'(1 << k) | 32'hA5A5_0000);
      wait_ready();
      for (int n = 0; n < NDOM; n++) rd_chk(8'(12 + 4*n), "R2 ratio up");
      wait_n(140);
    end
    // lower, bottom domain first
    for (int k = 6; k >= 0; k--) begin
      for (int n = 0; n < NDOM; n++) wr(8'(12 + 4*n), 32'(1 << k));
      wait_ready();
      for (int n = 0; n < NDOM; n++) rd_chk(8'(12 + 4*n), "R2 ratio down");
      wait_n(20);
    end
    // R4: ordering violations against d0=1, d1=4, d2=16
    wr(8'h14, 32'd16); wr(8'h10, 32'd4); wait_ready(); wait_n(130);
    wr(8'h0C, 32'd8);  chk(clk_ready == 1'b1, "R4 d0 above d1 ignored", clk_ready, 1);
    wr(8'h14, 32'd2);  chk(clk_ready == 1'b1, "R4 d2 below d1 ignored", clk_ready, 1);
    wr(8'h10, 32'd32); chk(clk_ready == 1'b1, "R4 d1 above d2 ignored", clk_ready, 1);
    wait_n(130);
    rd_chk(8'h0C, "R4 d0 kept"); rd_chk(8'h10, "R4 d1 kept"); rd_chk(8'h14, "R4 d2 kept");
    // R5/R7: read during pending shows committed ratio
    wr(8'h14, 32'd128);
    @(negedge clk); bus_addr = 8'h14; #1;
    chk(bus_rdata == 32'd16, "R7 committed read while pending", bus_rdata, 16);
    wait_ready(); rd_chk(8'h14, "R5 after switch");
    // R5: back-to-back writes while a slow switch waits
    wr(8'h10, 32'd64); wr(8'h10, 32'd2); wr(8'h10, 32'd128);
    wait_ready(); rd_chk(8'h10, "R5 last write wins");
    wr(8'h10, 32'd8); wait_ready();
    // R3: sweep all byte values into d1 with d0=1, d2=128
    for (int v = 0; v < 256; v++) begin
      old = 32'(8'd1 << mcur[1]);
      wr(8'h10, 32'(v) | 32'h1200_0000);
      wait_n(130);
      rd_chk(8'h10, "R3 sweep");
      if (!$onehot(v[7:0])) begin
        bus_addr = 8'h10; #1;
        chk(bus_rdata == old, "R3 illegal value ignored", bus_rdata, old);
      end
    end
    // R7: unmapped offsets read zero
    rd_chk(8'h00, "R7 unmapped"); rd_chk(8'h08, "R7 unmapped"); rd_chk(8'h18, "R7 unmapped");
    // R6/R8: software clear of ready
    wr(8'h10, 32'd4); wait_ready();
    wr(8'h04, 32'h0);
    chk(clk_ready == 1'b1, "R8 write zero keeps ready", clk_ready, 1);
    rd_chk(8'h04, "R7 status read");
    wr(8'h04, 32'h1);
    chk(clk_ready == 1'b0, "R6 write one clears ready", clk_ready, 0);
    rd_chk(8'h04, "R7 status read cleared");
    wait_n(10);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule